// File: doc/BRIEF.md
# Bit-Programmable Port Pattern Matcher

This block watches a parallel input port and decides, on every clock, whether the port has reached a condition that software has programmed bit by bit. First, a per-bit inversion mask is applied to the incoming data. Each bit can then be left out of the comparison, or required to sit at a given level, or required to show a rising, falling or any transition since the previous sample. The per-bit outcomes are merged by one of three rules: all of them together, any one of them, or any one of them with higher bit indices taking priority.

When a new match is found, a sticky match flag is set and a one-cycle interrupt strobe is issued. Software can also ask for the port data to be frozen at the moment of the match until it clears the flag. Configuration is written through a small register-select port. All outputs are registered, so the response to a sample appears one clock after that sample is presented.

Top module: `port_pattern_matcher`

## Requirements
- R1: After a synchronous active-high reset, all configuration registers are zero, and match_flag, held_data, irq_pulse and status are all zero.
- R2: A bit with mask=1 and transition=0 is satisfied when its inverted data bit equals its polarity bit: polarity 0 means a low level, polarity 1 means a high level.
- R3: A bit with mask=0 and transition=1 is satisfied by any change since the previous sample. A bit with mask=1 and transition=1 is satisfied by a 0-to-1 change when polarity is 1, and by a 1-to-0 change when polarity is 0. A bit with mask=0 and transition=0 never takes part.
- R4: In match rule 1 (all), a match event occurs when every participating bit is satisfied in the same sample and this was not already so in the previous sample. With no participating bits, no event ever occurs.
- R5: In match rule 2 (any), a match event occurs only when the OR of the participating bits goes from false to true.
- R6: In match rule 3 (priority), a match event occurs whenever the highest satisfied participating bit index is higher than it was in the previous sample, including a change from none satisfied.
- R7: In match rule 0 (off), no match event occurs.
- R8: The port data is XORed with the inversion register before matching and before being presented on held_data.
- R9: A match event sets match_flag one clock later. status bit 1 mirrors the flag and status bit 0 is (latch enable AND flag); all other status bits are 0. flag_clr clears the flag, and a match event in the same cycle wins over flag_clr.
- R10: held_data shows the inverted data of the previous sample. When mode bit 0 (latch) is 1 and the flag is set, held_data keeps the value captured at the match instead.
- R11: irq_pulse is high for one clock after a match event. When mode bit 3 (match-only) is 0, irq_pulse is also raised after any sample whose inverted data differs from the previous sample. When mode bit 3 is 1, only match events raise it.
- R12: Writing the mode register (cfg_sel 0; wdata bit 0 latch, bits 2:1 rule, bit 3 match-only) suppresses any match event in that cycle and clears the match history, so a still-present condition is reported again on the next sample. The other register selects are 1 mask, 2 transition, 3 polarity and 4 inversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| port_in | input | W | Sampled port bits |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Register select: 0 mode, 1 mask, 2 transition, 3 polarity, 4 inversion |
| cfg_wdata | input | W | Configuration write data |
| flag_clr | input | 1 | Clears the match flag |
| match_flag | output | 1 | Sticky match flag |
| held_data | output | W | Inverted port data, frozen on match when latching |
| irq_pulse | output | 1 | One-cycle interrupt strobe |
| status | output | 8 | Bit 1 flag, bit 0 data frozen |

## Verification
A single level-high bit under the any rule is used to show that a held condition is reported only once. A four-bit mixed low/high pattern under the all rule, tried one bit short and then complete, shows that partial matches are rejected. Rising, falling and any-edge bits are toggled in both directions, which separates the three transition encodings. A rising-then-falling sequence of level bits under the priority rule, with match-only interrupts enabled, separates the priority rule from the plain any rule, because only the priority rule reacts to the added higher bit. A long run of random configuration writes, port values and clears mixes rewrites of the mode in with every other input.

// File: rtl/ppm_pkg.sv
package ppm_pkg;

    localparam int SEL_W = 3;

    typedef enum logic [SEL_W-1:0] {
        SEL_MODE  = 3'd0,
        SEL_MASK  = 3'd1,
        SEL_TRANS = 3'd2,
        SEL_POL   = 3'd3,
        SEL_INV   = 3'd4
    } cfg_sel_e;

    typedef enum logic [1:0] {
        RULE_OFF  = 2'd0,
        RULE_ALL  = 2'd1,
        RULE_ANY  = 2'd2,
        RULE_PRIO = 2'd3
    } rule_e;

    // packed MSB first: bit3 match-only, bits2:1 rule, bit0 latch
    typedef struct packed {
        logic  match_only;
        rule_e rule;
        logic  latch;
    } mode_t;

    // outcome of one bit given its spec and two samples
    function automatic logic bit_hit(input logic pm, input logic pt, input logic pp,
                                     input logic cur, input logic prv);
        if (!pt)
            return pm & (cur == pp);
        if (!pm)
            return cur ^ prv;
        return pp ? (cur & ~prv) : (~cur & prv);
    endfunction

endpackage

// File: rtl/ppm_cfg_regs.sv
module ppm_cfg_regs
    import ppm_pkg::*;
#(
    parameter int W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [SEL_W-1:0] sel,
    input  logic [W-1:0]     wdata,
    output mode_t            mode_q,
    output logic [W-1:0]     mask_q,
    output logic [W-1:0]     trans_q,
    output logic [W-1:0]     pol_q,
    output logic [W-1:0]     inv_q,
    output logic             mode_wr
);
    localparam int MODE_W = $bits(mode_t);

    assign mode_wr = we && (cfg_sel_e'(sel) == SEL_MODE);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q  <= '0;
            mask_q  <= '0;
            trans_q <= '0;
            pol_q   <= '0;
            inv_q   <= '0;
        end else if (we) begin
            case (cfg_sel_e'(sel))
                SEL_MODE:  mode_q  <= mode_t'(wdata[MODE_W-1:0]);
                SEL_MASK:  mask_q  <= wdata;
                SEL_TRANS: trans_q <= wdata;
                SEL_POL:   pol_q   <= wdata;
                SEL_INV:   inv_q   <= wdata;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/ppm_bit_eval.sv
module ppm_bit_eval
    import ppm_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] cur,
    input  logic [W-1:0] prv,
    input  logic [W-1:0] mask,
    input  logic [W-1:0] trans,
    input  logic [W-1:0] pol,
    output logic [W-1:0] active,
    output logic [W-1:0] hit
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign active[i] = mask[i] | trans[i];
        assign hit[i]    = bit_hit(mask[i], trans[i], pol[i], cur[i], prv[i]);
    end
endmodule

// File: rtl/ppm_combine.sv
module ppm_combine
    import ppm_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  rule_e        rule,
    input  logic         mode_wr,
    input  logic [W-1:0] active,
    input  logic [W-1:0] hit,
    output logic         evt
);
    localparam int TW = $clog2(W + 1);

    logic          all_ok, any_ok, res_now, prev_res;
    logic [TW-1:0] top, prev_top;
    logic [W-1:0]  sat;

    assign sat    = hit & active;
    assign all_ok = (|active) && (&(hit | ~active));
    assign any_ok = |sat;

    always_comb begin
        top = '0;
        for (int i = 0; i < W; i++)
            if (sat[i]) top = TW'(i + 1);
    end

    always_comb begin
        res_now = 1'b0;
        evt     = 1'b0;
        case (rule)
            RULE_ALL: begin
                res_now = all_ok;
                evt     = all_ok && !prev_res;
            end
            RULE_ANY: begin
                res_now = any_ok;
                evt     = any_ok && !prev_res;
            end
            RULE_PRIO: evt = top > prev_top;
            default: ;
        endcase
        if (mode_wr) evt = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst || mode_wr) begin
            prev_res <= 1'b0;
            prev_top <= '0;
        end else begin
            prev_res <= res_now;
            prev_top <= top;
        end
    end
endmodule

// File: rtl/port_pattern_matcher.sv
module port_pattern_matcher
    import ppm_pkg::*;
#(
    parameter int W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [W-1:0]     port_in,
    input  logic             cfg_we,
    input  logic [SEL_W-1:0] cfg_sel,
    input  logic [W-1:0]     cfg_wdata,
    input  logic             flag_clr,
    output logic             match_flag,
    output logic [W-1:0]     held_data,
    output logic             irq_pulse,
    output logic [7:0]       status
);
    mode_t        mode_q;
    logic [W-1:0] mask_q, trans_q, pol_q, inv_q;
    logic         mode_wr;
    logic [W-1:0] cur, prev_q, active, hit;
    logic         match_evt, flag_q, irq_q;
    logic [W-1:0] data_q;
    logic         latch_en, imo_en, rule_off;

    ppm_cfg_regs #(.W(W)) u_cfg (
        .clk(clk), .rst(rst), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
        .mode_q(mode_q), .mask_q(mask_q), .trans_q(trans_q), .pol_q(pol_q),
        .inv_q(inv_q), .mode_wr(mode_wr)
    );

    assign cur = port_in ^ inv_q;

    ppm_bit_eval #(.W(W)) u_eval (
        .cur(cur), .prv(prev_q), .mask(mask_q), .trans(trans_q), .pol(pol_q),
        .active(active), .hit(hit)
    );

    ppm_combine #(.W(W)) u_comb (
        .clk(clk), .rst(rst), .rule(mode_q.rule), .mode_wr(mode_wr),
        .active(active), .hit(hit), .evt(match_evt)
    );

    assign latch_en = mode_q.latch;
    assign imo_en   = mode_q.match_only;
    assign rule_off = (mode_q.rule == RULE_OFF);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= '0;
            flag_q <= 1'b0;
            data_q <= '0;
            irq_q  <= 1'b0;
        end else begin
            prev_q <= cur;
            irq_q  <= match_evt || (!imo_en && !mode_wr && (cur != prev_q));
            if (!(latch_en && flag_q))
                data_q <= cur;
            if (match_evt)
                flag_q <= 1'b1;
            else if (flag_clr)
                flag_q <= 1'b0;
        end
    end

    assign match_flag = flag_q;
    assign held_data  = data_q;
    assign irq_pulse  = irq_q;
    assign status     = {6'b0, flag_q, latch_en & flag_q};
endmodule

// File: rtl/ppm_checker.sv
module ppm_checker #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         flag_clr,
    input logic         match_flag,
    input logic [W-1:0] held_data,
    input logic         irq_pulse,
    input logic         evt,
    input logic         latch_en,
    input logic         imo_en,
    input logic         rule_off,
    input logic         mode_wr
);
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        match_flag && !flag_clr |=> match_flag); // R9
    AST_FLAG_NEEDS_EVT: assert property (@(posedge clk) disable iff (rst)
        !match_flag && !evt |=> !match_flag); // R9
    AST_EVT_RESPONSE: assert property (@(posedge clk) disable iff (rst)
        evt |=> irq_pulse && match_flag); // R11
    AST_HELD_FROZEN: assert property (@(posedge clk) disable iff (rst)
        latch_en && match_flag |=> $stable(held_data)); // R10
    AST_IMO_QUIET: assert property (@(posedge clk) disable iff (rst)
        imo_en && !evt |=> !irq_pulse); // R11
    AST_OFF_SILENT: assert property (@(posedge clk) disable iff (rst)
        rule_off |-> !evt); // R7
    AST_WRITE_SILENT: assert property (@(posedge clk) disable iff (rst)
        mode_wr |-> !evt); // R12
endmodule

bind port_pattern_matcher ppm_checker #(.W(W)) u_ppm_chk (
    .clk(clk), .rst(rst), .flag_clr(flag_clr), .match_flag(match_flag),
    .held_data(held_data), .irq_pulse(irq_pulse), .evt(match_evt),
    .latch_en(latch_en), .imo_en(imo_en), .rule_off(rule_off), .mode_wr(mode_wr)
);

// File: tb/test_port_pattern_matcher.sv
module test_port_pattern_matcher;
    localparam int CLK_PERIOD = 10;

    logic       clk = 0;
    logic       rst = 1;
    logic [7:0] port_in = 0;
    logic       cfg_we = 0;
    logic [2:0] cfg_sel = 0;
    logic [7:0] cfg_wdata = 0;
    logic       flag_clr = 0;
    logic       match_flag, irq_pulse;
    logic [7:0] held_data, status;

    int    checks = 0, errors = 0;
    bit    started = 0, done = 0;
    string cur_req = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    port_pattern_matcher i_port_pattern_matcher (
        .clk(clk), .rst(rst), .port_in(port_in), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .flag_clr(flag_clr), .match_flag(match_flag),
        .held_data(held_data), .irq_pulse(irq_pulse), .status(status)
    );

    // behavioural reference model
    logic [7:0] m_mask = 0, m_trans = 0, m_pol = 0, m_inv = 0, m_prev = 0, m_data = 0;
    logic [3:0] m_mode = 0;
    bit m_flag = 0, m_irq = 0, m_res = 0;
    int m_top = 0;

    always @(posedge clk) begin : model
        logic [7:0] d;
        bit act, h, all_ok, any_ok, anyact, ev, mw, res;
        int top;
        if (rst) begin
            m_mask = 0; m_trans = 0; m_pol = 0; m_inv = 0; m_prev = 0; m_data = 0;
            m_mode = 0; m_flag = 0; m_irq = 0; m_res = 0; m_top = 0;
        end else begin
            d = port_in ^ m_inv;
            mw = cfg_we && cfg_sel == 3'd0;
            all_ok = 1; any_ok = 0; anyact = 0; top = 0;
            for (int i = 0; i < 8; i++) begin
                act = 1; h = 0;
                if (!m_mask[i] && !m_trans[i]) act = 0;
                else if (!m_mask[i]) h = d[i] != m_prev[i];
                else if (!m_trans[i]) h = d[i] == m_pol[i];
                else if (m_pol[i]) h = d[i] && !m_prev[i];
                else h = !d[i] && m_prev[i];
                if (act) begin
                    anyact = 1;
                    if (h) begin any_ok = 1; top = i + 1; end
                    else all_ok = 0;
                end
            end
            if (!anyact) all_ok = 0;
            ev = 0; res = 0;
            case (m_mode[2:1])
                2'd1: begin res = all_ok; ev = all_ok && !m_res; end
                2'd2: begin res = any_ok; ev = any_ok && !m_res; end
                2'd3: ev = top > m_top;
                default: ;
            endcase
            if (mw) ev = 0;
            m_irq = ev || (!m_mode[3] && !mw && d != m_prev);
            if (!(m_mode[0] && m_flag)) m_data = d;
            if (ev) m_flag = 1; else if (flag_clr) m_flag = 0;
            m_res = mw ? 0 : res;
            m_top = mw ? 0 : top;
            m_prev = d;
            if (cfg_we)
                case (cfg_sel)
                    3'd0: m_mode = cfg_wdata[3:0];
                    3'd1: m_mask = cfg_wdata;
                    3'd2: m_trans = cfg_wdata;
                    3'd3: m_pol = cfg_wdata;
                    3'd4: m_inv = cfg_wdata;
                    default: ;
                endcase
        end
    end

    // compare every cycle, away from the active edge
    always @(negedge clk) begin
        logic [18:0] act_v, exp_v;
        if (started && !done) begin
            act_v = {match_flag, irq_pulse, held_data, status[7:0]} [18:0];
            exp_v = {m_flag, m_irq, m_data, 6'b0, m_flag, m_mode[0] & m_flag};
            checks++;
            if (act_v !== exp_v) begin
                errors++;
                $display("FAIL %s model compare: actual %h expected %h", cur_req, act_v, exp_v);
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cyc(); @(negedge clk); endtask

    task automatic wr(input logic [2:0] s, input logic [7:0] v);
        cfg_we = 1; cfg_sel = s; cfg_wdata = v;
        cyc();
        cfg_we = 0;
    endtask

    task automatic clr();
        flag_clr = 1; cyc(); flag_clr = 0;
    endtask

    task automatic setup(input logic [7:0] mk, input logic [7:0] tr, input logic [7:0] pl,
                         input logic [7:0] md);
        wr(3'd1, mk); wr(3'd2, tr); wr(3'd3, pl); wr(3'd0, md); clr();
    endtask

    task automatic drive(input logic [7:0] p); port_in = p; cyc(); endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) cyc();
        rst = 0;
        cyc();
        started = 1;
        // R1 reset state
        chk("R1", {match_flag, irq_pulse, held_data, status}, 0);

        // R2 + R5: level high on bit0, any rule, reported once
        cur_req = "R5";
        port_in = 0;
        setup(8'h01, 8'h00, 8'h01, 8'h04);
        drive(8'h01);
        chk("R2", match_flag, 1);
        drive(8'h01);
        chk("R5", irq_pulse, 0);
        clr();
        chk("R9", {match_flag, status}, 0);
        cyc();
        chk("R5", match_flag, 0);

        // R2 low level + R4 all rule: pattern 0101 on low nibble
        cur_req = "R4";
        drive(8'h00);
        setup(8'h0F, 8'h00, 8'h05, 8'h02);
        drive(8'h04);
        chk("R4", match_flag, 0);
        drive(8'h05);
        chk("R4", match_flag, 1);
        // no participating bits
        setup(8'h00, 8'h00, 8'h00, 8'h02);
        drive(8'hFF); drive(8'h00);
        chk("R4", match_flag, 0);

        // R3 transitions on bit1
        cur_req = "R3";
        drive(8'h00);
        setup(8'h02, 8'h02, 8'h02, 8'h04);
        drive(8'h02);
        chk("R3", match_flag, 1);
        clr();
        drive(8'h00);
        chk("R3", match_flag, 0);
        wr(3'd3, 8'h00);
        drive(8'h02);
        chk("R3", match_flag, 0);
        drive(8'h00);
        chk("R3", match_flag, 1);
        setup(8'h00, 8'h02, 8'h00, 8'h04);
        drive(8'h02);
        chk("R3", match_flag, 1);
        setup(8'h00, 8'h00, 8'hFF, 8'h04);
        drive(8'h00); drive(8'hFF);
        chk("R3", match_flag, 0);

        // R6 priority rule with match-only interrupts
        cur_req = "R6";
        drive(8'h00);
        setup(8'hFF, 8'h00, 8'hFF, 8'h0E);
        drive(8'h01);
        chk("R6", irq_pulse, 1);
        drive(8'h03);
        chk("R6", irq_pulse, 1);
        drive(8'h01);
        chk("R6", irq_pulse, 0);
        drive(8'h81);
        chk("R6", irq_pulse, 1);

        // R7 off rule
        cur_req = "R7";
        drive(8'h00);
        setup(8'hFF, 8'h00, 8'hFF, 8'h00);
        drive(8'hFF); drive(8'h0F);
        chk("R7", match_flag, 0);

        // R8 inversion
        cur_req = "R8";
        wr(3'd4, 8'hFF);
        setup(8'h01, 8'h00, 8'h01, 8'h04);
        drive(8'hFE);
        chk("R8", {match_flag, held_data}, {1'b1, 8'h01});
        wr(3'd4, 8'h00);

        // R10 latching
        cur_req = "R10";
        drive(8'h10);
        setup(8'h01, 8'h00, 8'h01, 8'h05);
        drive(8'h11);
        chk("R10", {held_data, status}, {8'h11, 8'h03});
        drive(8'h20);
        chk("R10", held_data, 8'h11);
        clr();
        chk("R10", held_data, 8'h11);
        cyc();
        chk("R10", held_data, 8'h20);

        // R11 match-only versus data-change interrupts
        cur_req = "R11";
        setup(8'h01, 8'h00, 8'h01, 8'h0C);
        drive(8'h40);
        chk("R11", irq_pulse, 0);
        wr(3'd0, 8'h04);
        drive(8'h80);
        chk("R11", irq_pulse, 1);

        // R12 mode rewrite clears history
        cur_req = "R12";
        setup(8'h01, 8'h00, 8'h01, 8'h04);
        drive(8'h01);
        chk("R12", match_flag, 1);
        clr();
        wr(3'd0, 8'h04);
        chk("R12", match_flag, 0);
        cyc();
        chk("R12", match_flag, 1);

        // random mix
        cur_req = "R9";
        for (int i = 0; i < 4000; i++) begin
            cfg_we    = ($urandom % 6) == 0;
            cfg_sel   = 3'($urandom % 6);
            cfg_wdata = 8'($urandom);
            flag_clr  = ($urandom % 5) == 0;
            port_in   = (($urandom % 3) == 0) ? 8'($urandom) : port_in;
            cyc();
        end
        cfg_we = 0; flag_clr = 0;
        cyc();

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule